// File: doc/BRIEF.md
# Prefetch Confirmation-Bit Filter

This block sits on the path from a prefetch generator to the next memory level and decides which prefetch requests go forward. It holds one usefulness flag for each line of the next level. A line that was brought into the first-level cache by a prefetch and then thrown out without a single reference loses its flag. After that, prefetches to that line are discarded until the program itself misses on the line. Requests for lines that already sit in the first-level cache are discarded as well, because fetching them again would only waste bandwidth.

Requests enter on a valid/ready port. Each request carries the line address and a flag, sampled with it, that says whether the line is resident in the first-level cache. Surviving requests leave on a valid/ready port one cycle later, in arrival order. A request is accepted when `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is high whenever the output register is empty or is being drained in the same cycle. The upstream source must hold a request stable until it is accepted. The output holds its line stable while `pf_ready_i` is low. Discarded requests are still accepted, so that they leave the input port, but they never show up at the output. The first-level cache reports demand misses and unused evictions on two plain strobe-plus-address pins. A flush pin restores every flag.

Top module: `pf_confirm_filter`

## Requirements
- R1: After reset every line's flag is 1 and `pf_valid_o` is 0, so the first request to any line that is not resident is forwarded.
- R2: An unused-eviction event (`evict_unused_valid_i` high) clears the flag of `evict_unused_line_i`. The change becomes visible to lookups from the next cycle on.
- R3: A demand-miss event (`dmiss_valid_i` high) sets the flag of `dmiss_line_i`. The change becomes visible to lookups from the next cycle on. This is the only event, besides reset and flush, that sets a flag.
- R4: An accepted request whose line flag is 0 is squashed. It is consumed, and it is never presented on the output.
- R5: An accepted request with `req_in_l1_i` high is dropped without being forwarded, whatever the line's flag is.
- R6: An accepted request that is not resident and has its flag at 1 appears on `pf_valid_o`/`pf_line_o` in the cycle after acceptance. Survivors keep their arrival order. A lookup sees the flag values as they stood before any update made in the same cycle.
- R7: When a demand miss and an unused eviction name the same line in the same cycle, that line's flag ends up at 1.
- R8: A cycle with `flush_i` high sets every flag to 1, regardless of any event in that cycle.
- R9: `req_ready_o` equals `!pf_valid_o || pf_ready_i`. While `pf_valid_o` is high and `pf_ready_i` is low, the output stays valid and `pf_line_o` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Restore all flags to 1 |
| req_valid_i | input | 1 | Prefetch request valid |
| req_ready_o | output | 1 | Filter can accept a request |
| req_line_i | input | LINE_AW | Line address of the request |
| req_in_l1_i | input | 1 | Line already resident in first-level cache |
| dmiss_valid_i | input | 1 | Demand-miss event strobe |
| dmiss_line_i | input | LINE_AW | Line address of the demand miss |
| evict_unused_valid_i | input | 1 | Unused-prefetch eviction strobe |
| evict_unused_line_i | input | LINE_AW | Line address of the evicted line |
| pf_valid_o | output | 1 | Forwarded prefetch valid |
| pf_ready_i | input | 1 | Next level accepts the prefetch |
| pf_line_o | output | LINE_AW | Line address of the forwarded prefetch |

## Verification
A forwarded request is due on the output exactly one clock after the edge where it was accepted. A flag change made by an event, or by a flush, affects only lookups at the next edge and later. `req_ready_o` depends only on the current output state and `pf_ready_i` in the same cycle. The bench drives its inputs just after each falling edge and checks the outputs a moment later. It advances a behavioural model, made of a flag array and an output queue, on every rising edge using the same held inputs. Every cycle's expectation therefore follows these latencies exactly, including under back-pressure and same-cycle collisions.

// File: rtl/pcf_pkg.sv
package pcf_pkg;

  typedef enum logic [1:0] {
    VD_FORWARD  = 2'd0,
    VD_SQUASH   = 2'd1,
    VD_RESIDENT = 2'd2
  } verdict_e;

endpackage

// File: rtl/pcf_flag_array.sv
module pcf_flag_array #(
  parameter int LINE_AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic               set_v_i,
  input  logic [LINE_AW-1:0] set_line_i,
  input  logic               clr_v_i,
  input  logic [LINE_AW-1:0] clr_line_i,
  input  logic [LINE_AW-1:0] rd_line_i,
  output logic               rd_flag_o
);
  localparam int NLINES = 1 << LINE_AW;

  logic [NLINES-1:0] flags;

  for (genvar g = 0; g < NLINES; g++) begin : g_cell
    logic hit_set, hit_clr;
    assign hit_set = set_v_i && (set_line_i == LINE_AW'(g));
    assign hit_clr = clr_v_i && (clr_line_i == LINE_AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flags[g] <= 1'b1;
      else if (flush_i) flags[g] <= 1'b1;
      else if (hit_set) flags[g] <= 1'b1;
      else if (hit_clr) flags[g] <= 1'b0;
    end
  end

  assign rd_flag_o = flags[rd_line_i];

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    set_v_i && clr_v_i && (set_line_i == clr_line_i) |=> flags[$past(set_line_i)]); // R7
  AST_UNUSED_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_v_i && !flush_i && !(set_v_i && set_line_i == clr_line_i) |=> !flags[$past(clr_line_i)]); // R2
  AST_MISS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    set_v_i |=> flags[$past(set_line_i)]); // R3
  AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (&flags)); // R8

endmodule

// File: rtl/pcf_out_stage.sv
module pcf_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         keep_i,
  input  logic [W-1:0] load_data_i,
  output logic         in_ready_o,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o
);
  assign in_ready_o = !out_valid_o || out_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      if (in_ready_o) out_valid_o <= load_i && keep_i;
      if (in_ready_o && load_i && keep_i) out_data_o <= load_data_i;
    end
  end

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)); // R9

endmodule

// File: rtl/pf_confirm_filter.sv
module pf_confirm_filter
  import pcf_pkg::*;
#(
  parameter int LINE_AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [LINE_AW-1:0] req_line_i,
  input  logic               req_in_l1_i,
  input  logic               dmiss_valid_i,
  input  logic [LINE_AW-1:0] dmiss_line_i,
  input  logic               evict_unused_valid_i,
  input  logic [LINE_AW-1:0] evict_unused_line_i,
  output logic               pf_valid_o,
  input  logic               pf_ready_i,
  output logic [LINE_AW-1:0] pf_line_o
);
  logic     line_flag;
  verdict_e verdict;
  logic     accept;

  pcf_flag_array #(.LINE_AW(LINE_AW)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (flush_i),
    .set_v_i    (dmiss_valid_i),
    .set_line_i (dmiss_line_i),
    .clr_v_i    (evict_unused_valid_i),
    .clr_line_i (evict_unused_line_i),
    .rd_line_i  (req_line_i),
    .rd_flag_o  (line_flag)
  );

  always_comb begin
    if (req_in_l1_i)     verdict = VD_RESIDENT;
    else if (!line_flag) verdict = VD_SQUASH;
    else                 verdict = VD_FORWARD;
  end

  assign accept = req_valid_i && req_ready_o;

  pcf_out_stage #(.W(LINE_AW)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (req_valid_i),
    .keep_i      (verdict == VD_FORWARD),
    .load_data_i (req_line_i),
    .in_ready_o  (req_ready_o),
    .out_valid_o (pf_valid_o),
    .out_ready_i (pf_ready_i),
    .out_data_o  (pf_line_o)
  );

  AST_SQUASH_COLD: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !line_flag |=> !pf_valid_o); // R4
  AST_DROP_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_in_l1_i |=> !pf_valid_o); // R5
  AST_FORWARD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !req_in_l1_i && line_flag |=> pf_valid_o && pf_line_o == $past(req_line_i)); // R6

endmodule

// File: tb/pf_confirm_filter_tb.sv
module pf_confirm_filter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_AW = 8;
  localparam int NL = 1 << LINE_AW;

  logic clk = 0, rst_n = 0, flush = 0;
  logic req_valid = 0, req_in_l1 = 0, dmiss_v = 0, ev_v = 0, pf_ready = 1;
  logic [LINE_AW-1:0] req_line = '0, dmiss_line = '0, ev_line = '0;
  logic req_ready, pf_valid;
  logic [LINE_AW-1:0] pf_line;

  int checks = 0, errors = 0;
  bit done = 0;
  bit mflag [NL];
  logic [LINE_AW-1:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pf_confirm_filter #(.LINE_AW(LINE_AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_line_i(req_line),
    .req_in_l1_i(req_in_l1), .dmiss_valid_i(dmiss_v), .dmiss_line_i(dmiss_line),
    .evict_unused_valid_i(ev_v), .evict_unused_line_i(ev_line),
    .pf_valid_o(pf_valid), .pf_ready_i(pf_ready), .pf_line_o(pf_line)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    bit ev = (exp_q.size() != 0);
    chk(tag, "pf_valid", int'(pf_valid), int'(ev));
    if (ev) chk(tag, "pf_line", int'(pf_line), int'(exp_q[0]));
    chk("R9", "req_ready", int'(req_ready), int'(!ev || pf_ready));
  endtask

  task automatic model_edge();
    bit rdy = (exp_q.size() == 0) || pf_ready;
    if (exp_q.size() != 0 && pf_ready) void'(exp_q.pop_front());
    if (req_valid && rdy && !req_in_l1 && mflag[req_line]) exp_q.push_back(req_line);
    if (flush) begin
      foreach (mflag[i]) mflag[i] = 1;
    end else begin
      if (ev_v) mflag[ev_line] = 0;
      if (dmiss_v) mflag[dmiss_line] = 1;
    end
  endtask

  task automatic step(input string tag, input bit rv, input int rl, input bit l1,
                      input bit dv, input int dl, input bit evv, input int el,
                      input bit fl, input bit rdy);
    @(negedge clk);
    req_valid = rv; req_line = LINE_AW'(rl); req_in_l1 = l1;
    dmiss_v = dv; dmiss_line = LINE_AW'(dl); ev_v = evv; ev_line = LINE_AW'(el);
    flush = fl; pf_ready = rdy;
    #1 compare(tag);
    @(posedge clk);
    model_edge();
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    foreach (mflag[i]) mflag[i] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1 chk("R1", "pf_valid after reset", int'(pf_valid), 0);
    chk("R1", "req_ready after reset", int'(req_ready), 1);
    // R1: fresh lines forward; R6: next-cycle delivery in order
    step("R1", 1, 10, 0, 0, 0, 0, 0, 0, 1);
    step("R6", 1, 11, 0, 0, 0, 0, 0, 0, 1);
    step("R6", 1, 12, 0, 0, 0, 0, 0, 0, 1);
    idle("R6");
    // R2 then R4: unused eviction of 20, later request squashed
    step("R2", 0, 0, 0, 0, 0, 1, 20, 0, 1);
    step("R4", 1, 20, 0, 0, 0, 0, 0, 0, 1);
    idle("R4");
    // R6: lookup in same cycle as eviction sees old flag
    step("R6", 1, 21, 0, 0, 0, 1, 21, 0, 1);
    step("R4", 1, 21, 0, 0, 0, 0, 0, 0, 1);
    idle("R4");
    // R3: demand miss re-enables 20
    step("R3", 0, 0, 0, 1, 20, 0, 0, 0, 1);
    step("R3", 1, 20, 0, 0, 0, 0, 0, 0, 1);
    idle("R3");
    // R5: resident line dropped even with flag 1
    step("R5", 1, 30, 1, 0, 0, 0, 0, 0, 1);
    idle("R5");
    // R7: simultaneous set and clear on 40
    step("R7", 0, 0, 0, 1, 40, 1, 40, 0, 1);
    step("R7", 1, 40, 0, 0, 0, 0, 0, 0, 1);
    idle("R7");
    // R8: flush restores cleared lines, beats same-cycle eviction
    step("R8", 0, 0, 0, 0, 0, 1, 50, 0, 1);
    step("R8", 0, 0, 0, 0, 0, 1, 51, 1, 1);
    step("R8", 1, 50, 0, 0, 0, 0, 0, 0, 1);
    step("R8", 1, 51, 0, 0, 0, 0, 0, 0, 1);
    idle("R8");
    // R9: back-pressure holds output and blocks input
    step("R9", 1, 60, 0, 0, 0, 0, 0, 0, 1);
    step("R9", 1, 61, 0, 0, 0, 0, 0, 0, 0);
    step("R9", 1, 61, 0, 0, 0, 0, 0, 0, 0);
    step("R9", 1, 61, 0, 0, 0, 0, 0, 0, 1);
    idle("R9");
    idle("R9");
    // mixed random traffic on a few lines to force collisions
    for (int i = 0; i < 4000; i++) begin
      step("R6", ($urandom % 4) != 0, $urandom % 8, ($urandom % 5) == 0,
           ($urandom % 4) == 0, $urandom % 8, ($urandom % 3) == 0, $urandom % 8,
           ($urandom % 200) == 0, ($urandom % 3) != 0);
    end
    idle("R6");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule